// File: doc/BRIEF.md
# Pipelined Dual-Mode CORDIC Engine

This block is a fully pipelined circular CORDIC unit. Each cycle it can take one sample: signed x, y and z words, a mode bit and a valid strobe. In vectoring mode it turns the vector (x, y) onto the positive x axis. x then carries the vector length and z carries the accumulated phase. In rotation mode it turns (x, y) through the angle z. This converts polar coordinates to cartesian when y is zero, or rotates any vector by an angle.

Angles use a binary full-turn code: the whole z word is one revolution. Before the shift-and-add stages, an input stage moves the sample by a quarter turn when needed, so every angle and every quadrant converges. There is one register stage per iteration, and the valid flag and the mode bit travel with the data. Different modes can therefore be mixed from one sample to the next. The x and y results keep the CORDIC gain, which the block does not remove. Callers must leave two bits of headroom in x and y.

Top module: `cordic_pipe`

## Requirements
- R1: While rstN is low, outValid is 0. After release it stays 0 until an accepted sample has passed through the pipeline.
- R2: A sample accepted with inValid=1 at a clock edge appears with outValid=1 exactly ITERS+3 edges later. One sample is accepted per cycle and order is kept. Cycles with inValid=0 produce no output, whatever data is on the inputs then.
- R3: With inMode=1 (rotation), xOut = K(x·cosθ − y·sinθ) and yOut = K(x·sinθ + y·cosθ), where θ is zIn in full-turn code. zOut is a residual angle close to zero.
- R4: With inMode=0 (vectoring, zIn=0), xOut = K·sqrt(x²+y²) and xOut is never negative. yOut is close to zero.
- R5: Angle code: z is two's complement, one full turn equals 2^Z_W, and −2^(Z_W−1) is −π. In vectoring, zOut = zIn + atan2(y, x) modulo one turn for inputs in all four quadrants, including the negative x axis. Rotation accepts any z word, including −π and ±π/2.
- R6: The mode is chosen per sample. Alternating inMode every cycle gives each sample the result of its own mode.
- R7: The x/y gain is uncompensated: K = ∏_{i<ITERS} sqrt(1 + 2^(−2i)), about 1.6468 for 14 iterations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Sample strobe |
| inMode | input | 1 | 1 = rotation, 0 = vectoring |
| xIn | input | XY_W | Signed x |
| yIn | input | XY_W | Signed y |
| zIn | input | Z_W | Signed angle, full-turn code |
| outValid | output | 1 | Result strobe |
| xOut | output | XY_W | Signed x result (with gain) |
| yOut | output | XY_W | Signed y result (with gain) |
| zOut | output | Z_W | Phase (vectoring) or residual angle (rotation) |

## Verification
The hardest case to reach from the ports is a pipeline that holds a mix of rotation and vectoring samples at the same moment, with samples sitting on quadrant boundaries where the quarter-turn correction changes direction. The stimulus sweeps the whole circle in 256 steps. It interleaves a rotation sample and a vectoring sample on consecutive cycles, so each stage flips mode every cycle. It then adds the exact angles −π and ±π/2 and a vector on the negative x axis. A final phase breaks the stream with idle cycles that carry junk data, to check that data and strobe stay aligned.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // Per-stage strobe handed from control to datapath
  typedef struct packed {
    logic load;    // stage register captures this cycle
    logic rotate;  // sample moving into the stage is in rotation mode
  } stageCtlT;

  localparam real TWO_PI = 6.283185307179586;

  // atan(2^-idx) in full-turn units of a zw-bit angle word, rounded
  function automatic int arcStep(int idx, int zw);
    real turn;
    real r;
    turn = 2.0 ** zw;
    r = $atan(2.0 ** (-idx)) / TWO_PI * turn;
    return $rtoi(r + 0.5);
  endfunction

endpackage

// File: rtl/cordic_ctl.sv
module cordic_ctl
  import cordic_pkg::*;
#(
  parameter int NST = 17
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  inValid,
  input  logic                  inMode,
  output stageCtlT [NST-1:0]    ctl,
  output logic                  outValid,
  output logic                  outRot
);

  logic [NST-1:0] validPipe;
  logic [NST-1:0] rotPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validPipe <= '0;
      rotPipe   <= '0;
    end else begin
      validPipe <= {validPipe[NST-2:0], inValid};
      rotPipe   <= {rotPipe[NST-2:0], inMode};
    end
  end

  always_comb begin
    ctl[0].load   = inValid;
    ctl[0].rotate = inMode;
    for (int k = 1; k < NST; k++) begin
      ctl[k].load   = validPipe[k-1];
      ctl[k].rotate = rotPipe[k-1];
    end
  end

  assign outValid = validPipe[NST-1];
  assign outRot   = rotPipe[NST-1];

endmodule

// File: rtl/cordic_step.sv
module cordic_step #(
  parameter int XY_W  = 16,
  parameter int Z_W   = 16,
  parameter int SHIFT = 0,
  parameter int ANGLE = 0
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   load,
  input  logic                   rotate,
  input  logic signed [XY_W-1:0] xI,
  input  logic signed [XY_W-1:0] yI,
  input  logic signed [Z_W-1:0]  zI,
  output logic signed [XY_W-1:0] xO,
  output logic signed [XY_W-1:0] yO,
  output logic signed [Z_W-1:0]  zO
);

  localparam logic signed [Z_W-1:0] ANG = Z_W'(ANGLE);

  logic signed [XY_W-1:0] dx, dy;
  logic cw;

  assign dx = xI >>> SHIFT;
  assign dy = yI >>> SHIFT;
  // clockwise when the rotation angle left is negative, or the vector lies on or above the axis
  assign cw = rotate ? zI[Z_W-1] : ~yI[XY_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xO <= '0;
      yO <= '0;
      zO <= '0;
    end else if (load) begin
      if (cw) begin
        xO <= xI + dy;
        yO <= yI - dx;
        zO <= zI + ANG;
      end else begin
        xO <= xI - dy;
        yO <= yI + dx;
        zO <= zI - ANG;
      end
    end
  end

endmodule

// File: rtl/cordic_dp.sv
module cordic_dp
  import cordic_pkg::*;
#(
  parameter int XY_W  = 16,
  parameter int Z_W   = 16,
  parameter int ITERS = 14,
  localparam int NST  = ITERS + 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  stageCtlT [NST-1:0]     ctl,
  input  logic signed [XY_W-1:0] xIn,
  input  logic signed [XY_W-1:0] yIn,
  input  logic signed [Z_W-1:0]  zIn,
  output logic signed [XY_W-1:0] xOut,
  output logic signed [XY_W-1:0] yOut,
  output logic signed [Z_W-1:0]  zOut
);

  localparam logic signed [Z_W-1:0] QUARTER = {2'b01, {(Z_W-2){1'b0}}};

  logic signed [XY_W-1:0] xReg, yReg, xPre, yPre, xRot, yRot;
  logic signed [Z_W-1:0]  zReg, zPre, zRot;
  logic signed [XY_W-1:0] xc [ITERS+1];
  logic signed [XY_W-1:0] yc [ITERS+1];
  logic signed [Z_W-1:0]  zc [ITERS+1];
  logic unusedRotBits;

  assign unusedRotBits = ^{ctl[0].rotate, ctl[NST-1].rotate};

  // input register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xReg <= '0; yReg <= '0; zReg <= '0;
    end else if (ctl[0].load) begin
      xReg <= xIn; yReg <= yIn; zReg <= zIn;
    end
  end

  // quarter-turn pre-rotation into the convergence range
  always_comb begin
    xRot = xReg; yRot = yReg; zRot = zReg;
    if (ctl[1].rotate) begin
      case (zReg[Z_W-1 -: 2])
        2'b01: begin xRot = -yReg; yRot = xReg;  zRot = zReg - QUARTER; end
        2'b10: begin xRot = yReg;  yRot = -xReg; zRot = zReg + QUARTER; end
        default: ;
      endcase
    end else if (xReg[XY_W-1]) begin
      if (!yReg[XY_W-1]) begin
        xRot = yReg;  yRot = -xReg; zRot = zReg + QUARTER;
      end else begin
        xRot = -yReg; yRot = xReg;  zRot = zReg - QUARTER;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xPre <= '0; yPre <= '0; zPre <= '0;
    end else if (ctl[1].load) begin
      xPre <= xRot; yPre <= yRot; zPre <= zRot;
    end
  end

  assign xc[0] = xPre;
  assign yc[0] = yPre;
  assign zc[0] = zPre;

  for (genvar i = 0; i < ITERS; i++) begin : gIter
    cordic_step #(
      .XY_W (XY_W),
      .Z_W  (Z_W),
      .SHIFT(i),
      .ANGLE(arcStep(i, Z_W))
    ) uStep (
      .clk   (clk),
      .rstN  (rstN),
      .load  (ctl[i+2].load),
      .rotate(ctl[i+2].rotate),
      .xI    (xc[i]),
      .yI    (yc[i]),
      .zI    (zc[i]),
      .xO    (xc[i+1]),
      .yO    (yc[i+1]),
      .zO    (zc[i+1])
    );
  end

  // output register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xOut <= '0; yOut <= '0; zOut <= '0;
    end else if (ctl[NST-1].load) begin
      xOut <= xc[ITERS]; yOut <= yc[ITERS]; zOut <= zc[ITERS];
    end
  end

endmodule

// File: rtl/cordic_pipe.sv
module cordic_pipe
  import cordic_pkg::*;
#(
  parameter int XY_W  = 16,
  parameter int Z_W   = 16,
  parameter int ITERS = 14
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   inValid,
  input  logic                   inMode,
  input  logic signed [XY_W-1:0] xIn,
  input  logic signed [XY_W-1:0] yIn,
  input  logic signed [Z_W-1:0]  zIn,
  output logic                   outValid,
  output logic signed [XY_W-1:0] xOut,
  output logic signed [XY_W-1:0] yOut,
  output logic signed [Z_W-1:0]  zOut
);

  localparam int NST = ITERS + 3;

  stageCtlT [NST-1:0] ctl;
  logic outRot;

  cordic_ctl #(.NST(NST)) uCtl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inMode  (inMode),
    .ctl     (ctl),
    .outValid(outValid),
    .outRot  (outRot)
  );

  cordic_dp #(.XY_W(XY_W), .Z_W(Z_W), .ITERS(ITERS)) uDp (
    .clk (clk),
    .rstN(rstN),
    .ctl (ctl),
    .xIn (xIn),
    .yIn (yIn),
    .zIn (zIn),
    .xOut(xOut),
    .yOut(yOut),
    .zOut(zOut)
  );

endmodule

// File: rtl/cordic_chk.sv
module cordic_chk #(
  parameter int XY_W  = 16,
  parameter int Z_W   = 16,
  parameter int ITERS = 14
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   inValid,
  input logic                   outValid,
  input logic                   outRot,
  input logic signed [XY_W-1:0] xOut,
  input logic signed [XY_W-1:0] yOut,
  input logic signed [Z_W-1:0]  zOut
);

  localparam int LAT = ITERS + 3;
  localparam int FW  = $clog2(LAT + 2) + 1;
  localparam logic signed [Z_W-1:0] RES_LIM = {5'b00001, {(Z_W-5){1'b0}}};

  logic [FW-1:0] inFlight;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) inFlight <= '0;
    else       inFlight <= inFlight + FW'(inValid) - FW'(outValid);
  end

  // R1: no result strobe while reset is held
  p_quiet_reset_r1: assert property (@(posedge clk) !rstN |-> !outValid);

  // R2: never more samples inside than stages, never a result with nothing inside
  p_inflight_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    inFlight <= FW'(LAT));
  p_no_phantom_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> inFlight != '0);

  // R2: result words hold while no new result arrives
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(xOut) && $stable(yOut) && $stable(zOut)));

  // R4: vectoring length is non-negative
  p_vec_len_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outRot) |-> !xOut[XY_W-1]);

  // R3: rotation leaves only a small residual angle
  p_rot_residual_r3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outRot) |-> (zOut < RES_LIM && zOut > -RES_LIM));

endmodule

bind cordic_pipe cordic_chk #(.XY_W(XY_W), .Z_W(Z_W), .ITERS(ITERS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .inValid (inValid),
  .outValid(outValid),
  .outRot  (outRot),
  .xOut    (xOut),
  .yOut    (yOut),
  .zOut    (zOut)
);

// File: tb/sim_cordic_pipe.sv
`timescale 1ns/1ps
module sim_cordic_pipe;

  localparam int XY_W  = 16;
  localparam int Z_W   = 16;
  localparam int ITERS = 14;
  localparam int LAT   = ITERS + 3;
  localparam int TOL   = 24;
  localparam int DEPTH = 1024;
  localparam real TWO_PI = 6.283185307179586;

  logic clk = 1'b0;
  logic rstN;
  logic inValid, inMode;
  logic signed [XY_W-1:0] xIn, yIn, xOut, yOut;
  logic signed [Z_W-1:0]  zIn, zOut;
  logic outValid;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr = 0;
  int rd = 0;

  int    sMode [DEPTH];
  int    sX    [DEPTH];
  int    sY    [DEPTH];
  int    sZ    [DEPTH];
  int    sCyc  [DEPTH];
  string sTag  [DEPTH];

  real gainK;

  cordic_pipe #(.XY_W(XY_W), .Z_W(Z_W), .ITERS(ITERS)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inMode(inMode),
    .xIn(xIn), .yIn(yIn), .zIn(zIn),
    .outValid(outValid), .xOut(xOut), .yOut(yOut), .zOut(zOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int rnd(real r);
    return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
  endfunction

  task automatic chk(string req, string what, int act, int exp, int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic send(string tag, int mode, int x, int y, int z);
    @(negedge clk);
    inValid = 1'b1;
    inMode  = mode[0];
    xIn = XY_W'(x); yIn = XY_W'(y); zIn = Z_W'(z);
    sMode[wr] = mode; sX[wr] = x; sY[wr] = y; sZ[wr] = z;
    sCyc[wr] = cyc; sTag[wr] = tag;
    wr++;
  endtask

  // idle cycle carrying junk data that must be ignored (R2)
  task automatic idle(int junk);
    @(negedge clk);
    inValid = 1'b0;
    inMode  = junk[0];
    xIn = XY_W'(junk * 977); yIn = XY_W'(-junk * 311); zIn = Z_W'(junk * 4099);
  endtask

  // output monitor: compares every result against arithmetic expectations
  always @(negedge clk) begin
    if (rstN && outValid) begin
      if (rd >= wr) begin
        checks++;
        errors++;
        $display("FAIL R2 unexpected result: actual outValid 1 expected 0");
      end else begin
        automatic real ang, ex, ey, ph;
        automatic int ez;
        automatic logic signed [Z_W-1:0] zd;
        chk("R2", "latency", cyc - sCyc[rd], LAT, 0);
        if (sMode[rd] == 1) begin
          ang = real'(sZ[rd]) * TWO_PI / (2.0 ** Z_W);
          ex = gainK * (sX[rd] * $cos(ang) - sY[rd] * $sin(ang));
          ey = gainK * (sX[rd] * $sin(ang) + sY[rd] * $cos(ang));
          chk({sTag[rd], ",R3,R7"}, "rot x", int'(xOut), rnd(ex), TOL);
          chk({sTag[rd], ",R3,R7"}, "rot y", int'(yOut), rnd(ey), TOL);
          chk({sTag[rd], ",R3"}, "rot residual z", int'(zOut), 0, TOL);
        end else begin
          ex = gainK * $sqrt(real'(sX[rd]) * sX[rd] + real'(sY[rd]) * sY[rd]);
          chk({sTag[rd], ",R4,R7"}, "vec length", int'(xOut), rnd(ex), TOL);
          chk({sTag[rd], ",R4"}, "vec y", int'(yOut), 0, TOL);
          ph = $atan2(real'(sY[rd]), real'(sX[rd])) * (2.0 ** Z_W) / TWO_PI;
          ez = rnd(ph) + sZ[rd];
          zd = zOut - Z_W'(ez);
          chk({sTag[rd], ",R5"}, "vec phase error", int'(zd), 0, TOL);
        end
      end
      rd++;
    end
  end

  initial begin
    gainK = 1.0;
    for (int i = 0; i < ITERS; i++) gainK = gainK * $sqrt(1.0 + 2.0 ** (-2 * i));

    rstN = 1'b1; inValid = 1'b0; inMode = 1'b0;
    xIn = '0; yIn = '0; zIn = '0;
    #1 rstN = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "outValid during reset", int'(outValid), 0, 0);
    end
    rstN = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R1", "outValid after reset", int'(outValid), 0, 0);
    end

    // R6: full-circle sweep, rotation and vectoring alternate every cycle
    for (int k = 0; k < 256; k++) begin
      automatic int z = k * 256 - ((k >= 128) ? 65536 : 0);
      automatic real a = real'(z) * TWO_PI / 65536.0;
      send("R6", 1, 6000, 0, z);
      send("R6", 0, rnd(6000.0 * $cos(a)), rnd(6000.0 * $sin(a)), 0);
    end

    // R5: exact boundary angles and axes
    send("R5", 1, 6000, 0, -32768);
    send("R5", 1, 6000, 0, 16384);
    send("R5", 1, 6000, 0, -16384);
    send("R5", 1, 6000, 0, 16383);
    send("R5", 0, -5000, 0, 0);
    send("R5", 0, 0, 5000, 0);
    send("R5", 0, 0, -5000, 0);
    send("R5", 0, -4000, -1, 0);
    send("R5", 0, 7000, 0, 0);

    // R3: rotating general vectors by arbitrary angles
    for (int k = 0; k < 64; k++) begin
      automatic int x = ((k * 1237) % 9000) - 4500;
      automatic int y = ((k * 2711) % 9000) - 4500;
      automatic int z = ((k * 10007) % 65536) - 32768;
      send("R3", 1, x, y, z);
    end

    // R2: stream broken by idle cycles carrying junk
    for (int k = 0; k < 90; k++) begin
      if (k % 3 == 0) idle(k + 5);
      else if (k % 2 == 0) send("R2", 1, 3000 + k * 10, -2000, k * 700);
      else send("R2", 0, -3000 + k * 20, 2500 - k * 40, 0);
    end
    idle(1);

    for (int i = 0; i < LAT + 20; i++) @(negedge clk);
    chk("R2", "results received", rd, wr, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule